// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Front End

This block gathers up to 32 level-sensitive interrupt requests and turns them into two processor-facing outputs: a normal interrupt line and a fast interrupt line. Each source is active while its hardware request input is high or its software request bit is set. A per-source routing register sends each source either to the fast line or to the normal line. Only the normal path is gated by the per-source enable register; a source routed to the fast line reaches it whether or not it is enabled.

Software reaches the block through a 32-bit register bus that is addressed by word. There are separate set and clear addresses for the enable and software-request registers, so one bit can be changed without a read-modify-write. Three status views can be read: the raw active sources, the masked normal-path vector and the fast-path vector. There is also a one-bit protection flag and an eight-word identification area. The block also drives out the masked normal-path vector, which a downstream prioritiser can use.

Top module: `irq_route_front`

## Requirements
- R1: A cycle with `rst_n` low at the clock edge clears the enable, software-request, fast-route and protection registers. The same edge drives `irq_out`, `fiq_out`, `irq_pend` and `bus_rdata` to zero.
- R2: A source is active when its `src_req` bit or its software-request bit is 1. Word 2 (byte 0x008) reads the active vector. Word 0 (byte 0x000) reads active AND enable AND NOT fast-route. Word 1 (byte 0x004) reads active AND fast-route.
- R3: `irq_pend` equals the word-0 vector as it stood before the previous clock edge. `irq_out` is 1 when any bit of that vector was 1.
- R4: `fiq_out` is 1 one cycle after any active source has its fast-route bit set. The enable register has no effect on it.
- R5: A write to word 4 (byte 0x010) ORs the data into the enable register. A write to word 5 (byte 0x014) clears every enable bit where the data is 1. A read of word 4 returns the enable register.
- R6: A write to word 6 (byte 0x018) sets software-request bits where the data is 1. A write to word 7 (byte 0x01C) clears them. A read of word 6 returns the software-request register.
- R7: Word 3 (byte 0x00C) is the fast-route register. A write replaces all of its bits, and a read returns it.
- R8: Word 8 (byte 0x020) holds the protection flag in bit 0. A write loads bit 0 of the data. A read returns the flag in bit 0, with every other bit zero.
- R9: Words 0x3F8 to 0x3FF (bytes 0xFE0 to 0xFFC) read, in rising address order, the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with bits 31:8 zero.
- R10: Reads of words 5, 7, 9 to 0x3F7 return zero. Writes to words 0, 1, 2 and 9 to 0x3FF change no register.
- R11: `bus_rdata` carries the read result in the cycle after `bus_rd` was sampled high, and is zero in the cycle after `bus_rd` was low. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | N_SRC | Hardware interrupt request levels |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_rd | input | 1 | Read strobe for the addressed word |
| bus_word | input | 10 | Word address (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt output |
| fiq_out | output | 1 | Fast interrupt output |
| irq_pend | output | N_SRC | Registered masked normal-path vector |

## Verification
Two operations can fall in the same cycle: a read and a write to the same register word, and a software-request clear while the hardware line of that source is still high. The bench provokes the first with one directed access that raises both strobes on the enable word; that read must return the old enable value. A random phase then mixes both cases with changing request levels. A behavioural reference model predicts the outputs and read data every cycle, so the bench judges a same-cycle collision by whether the pre-write value comes back and whether the source stays active through its hardware line.

// File: rtl/irqrf_pkg.sv
// Package: shared constants for the interrupt routing front end.
// Holds the bus width, word-address width, register word map and the
// identification byte table used by the read path.
package irqrf_pkg;

    localparam int BUS_W  = 32;
    localparam int WORD_W = 10;

    // Register word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_IRQ_STAT = 10'h000;
    localparam logic [WORD_W-1:0] W_FIQ_STAT = 10'h001;
    localparam logic [WORD_W-1:0] W_RAW      = 10'h002;
    localparam logic [WORD_W-1:0] W_ROUTE    = 10'h003;
    localparam logic [WORD_W-1:0] W_EN_SET   = 10'h004;
    localparam logic [WORD_W-1:0] W_EN_CLR   = 10'h005;
    localparam logic [WORD_W-1:0] W_SW_SET   = 10'h006;
    localparam logic [WORD_W-1:0] W_SW_CLR   = 10'h007;
    localparam logic [WORD_W-1:0] W_PROT     = 10'h008;

    // Identification block occupies the last eight words
    localparam int ID_IDX_W = 3;
    localparam logic [WORD_W-ID_IDX_W-1:0] ID_BLOCK = '1;

    // Identification byte for a given word inside the block
    function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h90;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irqrf_regs.sv
// Module: irqrf_regs
// Holds the software-visible control state: per-source enable and
// software-request bits (set/clear addressed), the fast-route selector
// and the protection flag.
// Assumes: N_SRC <= BUS_W; write data bit i addresses source i.
module irqrf_regs
    import irqrf_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [BUS_W-1:0]  wdata,
    output logic [N_SRC-1:0]  en_q,
    output logic [N_SRC-1:0]  soft_q,
    output logic [N_SRC-1:0]  sel_q,
    output logic              prot_q
);

    logic en_set, en_clr, sw_set, sw_clr, route_wr, prot_wr;

    // Decode the write strobe into one-hot register actions
    always_comb begin
        en_set   = wr_en && (wr_word == W_EN_SET);
        en_clr   = wr_en && (wr_word == W_EN_CLR);
        sw_set   = wr_en && (wr_word == W_SW_SET);
        sw_clr   = wr_en && (wr_word == W_SW_CLR);
        route_wr = wr_en && (wr_word == W_ROUTE);
        prot_wr  = wr_en && (wr_word == W_PROT);
    end

    for (genvar b = 0; b < N_SRC; b++) begin : g_src
        logic en_b, soft_b;

        // Per-source enable and software-request set/clear cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_b   <= 1'b0;
                soft_b <= 1'b0;
            end else begin
                if (en_set && wdata[b])
                    en_b <= 1'b1;
                else if (en_clr && wdata[b])
                    en_b <= 1'b0;
                if (sw_set && wdata[b])
                    soft_b <= 1'b1;
                else if (sw_clr && wdata[b])
                    soft_b <= 1'b0;
            end
        end

        assign en_q[b]   = en_b;
        assign soft_q[b] = soft_b;
    end

    // Fast-route selector and protection flag, plain load on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            prot_q <= 1'b0;
        end else begin
            if (route_wr)
                sel_q <= wdata[N_SRC-1:0];
            if (prot_wr)
                prot_q <= wdata[0];
        end
    end

endmodule

// File: rtl/irqrf_route.sv
// Module: irqrf_route
// Forms the active, normal-path and fast-path vectors and registers the
// two interrupt outputs and the masked vector.
// Assumes: request inputs are already synchronous to clk.
module irqrf_route #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] en_q,
    input  logic [N_SRC-1:0] soft_q,
    input  logic [N_SRC-1:0] sel_q,
    output logic [N_SRC-1:0] raw_vec,
    output logic [N_SRC-1:0] irq_vec,
    output logic [N_SRC-1:0] fiq_vec,
    output logic [N_SRC-1:0] irq_pend,
    output logic             irq_out,
    output logic             fiq_out
);

    // Combine request sources and split them by route
    always_comb begin
        raw_vec = src_req | soft_q;
        irq_vec = raw_vec & en_q & ~sel_q;
        fiq_vec = raw_vec & sel_q;
    end

    // Register the outputs so they are glitch-free toward the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= '0;
            irq_out  <= 1'b0;
            fiq_out  <= 1'b0;
        end else begin
            irq_pend <= irq_vec;
            irq_out  <= |irq_vec;
            fiq_out  <= |fiq_vec;
        end
    end

endmodule

// File: rtl/irqrf_rdmux.sv
// Module: irqrf_rdmux
// Selects the addressed register view and registers it onto the read bus.
// Assumes: one read per cycle; idle cycles return zero on the bus.
module irqrf_rdmux
    import irqrf_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [N_SRC-1:0]  raw_vec,
    input  logic [N_SRC-1:0]  irq_vec,
    input  logic [N_SRC-1:0]  fiq_vec,
    input  logic [N_SRC-1:0]  en_q,
    input  logic [N_SRC-1:0]  soft_q,
    input  logic [N_SRC-1:0]  sel_q,
    input  logic              prot_q,
    output logic [BUS_W-1:0]  rdata
);

    logic [BUS_W-1:0] rd_val;

    // Address decode of the readable views
    always_comb begin
        rd_val = '0;
        if (rd_word[WORD_W-1:ID_IDX_W] == ID_BLOCK) begin
            rd_val = BUS_W'(id_byte(rd_word[ID_IDX_W-1:0]));
        end else begin
            case (rd_word)
                W_IRQ_STAT: rd_val = BUS_W'(irq_vec);
                W_FIQ_STAT: rd_val = BUS_W'(fiq_vec);
                W_RAW:      rd_val = BUS_W'(raw_vec);
                W_ROUTE:    rd_val = BUS_W'(sel_q);
                W_EN_SET:   rd_val = BUS_W'(en_q);
                W_SW_SET:   rd_val = BUS_W'(soft_q);
                W_PROT:     rd_val = BUS_W'(prot_q);
                default:    rd_val = '0;
            endcase
        end
    end

    // Register read data; zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
        else
            rdata <= '0;
    end

endmodule

// File: rtl/irq_route_front.sv
// Module: irq_route_front
// Top of the interrupt source masking and routing front end. It joins the
// control registers, the routing logic and the read multiplexer.
// Assumes: N_SRC <= 32; word-addressed bus with independent read and
// write strobes that may both be high in one cycle.
module irq_route_front
    import irqrf_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_out,
    output logic              fiq_out,
    output logic [N_SRC-1:0]  irq_pend
);

    logic [N_SRC-1:0] en_q, soft_q, sel_q;
    logic             prot_q;
    logic [N_SRC-1:0] raw_vec, irq_vec, fiq_vec;

    irqrf_regs #(.N_SRC(N_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_word (bus_word),
        .wdata   (bus_wdata),
        .en_q    (en_q),
        .soft_q  (soft_q),
        .sel_q   (sel_q),
        .prot_q  (prot_q)
    );

    irqrf_route #(.N_SRC(N_SRC)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .en_q     (en_q),
        .soft_q   (soft_q),
        .sel_q    (sel_q),
        .raw_vec  (raw_vec),
        .irq_vec  (irq_vec),
        .fiq_vec  (fiq_vec),
        .irq_pend (irq_pend),
        .irq_out  (irq_out),
        .fiq_out  (fiq_out)
    );

    irqrf_rdmux #(.N_SRC(N_SRC)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .rd_word (bus_word),
        .raw_vec (raw_vec),
        .irq_vec (irq_vec),
        .fiq_vec (fiq_vec),
        .en_q    (en_q),
        .soft_q  (soft_q),
        .sel_q   (sel_q),
        .prot_q  (prot_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/irqrf_chk.sv
// Module: irqrf_chk
// Property checker for irq_route_front, attached by bind below.
// Assumes: synchronous active-low reset; properties idle while in reset.
module irqrf_chk
    import irqrf_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_req,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  soft_q,
    input logic [N_SRC-1:0]  sel_q,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_word,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq_out,
    input logic              fiq_out,
    input logic [N_SRC-1:0]  irq_pend
);

    // R1: first cycle out of reset sees cleared state and quiet outputs
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && !fiq_out && en_q == '0 && soft_q == '0 && sel_q == '0));

    // R3: masked vector follows sources, enable and route one cycle later
    p_pend_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_pend == $past((src_req | soft_q) & en_q & ~sel_q));

    // R4: fast output ignores enable
    p_fiq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fiq_out == $past(|((src_req | soft_q) & sel_q)));

    // R5: set-write leaves every written one set in the enable register
    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == W_EN_SET) |=>
            ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    // R6: clear-write removes every written one from software requests
    p_sw_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == W_SW_CLR) |=> ((soft_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    // R11: no read strobe, zero read data the next cycle
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind irq_route_front irqrf_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .en_q      (en_q),
    .soft_q    (soft_q),
    .sel_q     (sel_q),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .irq_pend  (irq_pend)
);

// File: tb/irq_route_front_bench.sv
// Bench: irq_route_front_bench
// Behavioural reference model updated on each rising edge and compared on
// each falling edge, plus directed reads with literal expected values.
module irq_route_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;
    logic [31:0] irq_pend;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_front #(.N_SRC(32)) u_irq_route_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out),
        .irq_pend  (irq_pend)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_en = '0, m_soft = '0, m_sel = '0;
    logic        m_prot = 1'b0;
    logic [31:0] e_rdata = '0, e_pend = '0;
    logic        e_irq = 1'b0, e_fiq = 1'b0;
    string       e_tag = "R11";
    logic [7:0]  id_tab [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic string tag_of(input logic [9:0] w);
        if (w >= 10'h3F8) return "R9";
        case (w)
            10'd0, 10'd1, 10'd2: return "R2";
            10'd3:               return "R7";
            10'd4:               return "R5";
            10'd6:               return "R6";
            10'd8:               return "R8";
            default:             return "R10";
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [9:0] w, input logic [31:0] act);
        if (w >= 10'h3F8) return {24'h0, id_tab[w - 10'h3F8]};
        case (w)
            10'd0:   return act & m_en & ~m_sel;
            10'd1:   return act & m_sel;
            10'd2:   return act;
            10'd3:   return m_sel;
            10'd4:   return m_en;
            10'd6:   return m_soft;
            10'd8:   return {31'h0, m_prot};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] act;
        if (!rst_n) begin
            m_en = '0; m_soft = '0; m_sel = '0; m_prot = 1'b0;
            e_rdata = '0; e_pend = '0; e_irq = 1'b0; e_fiq = 1'b0; e_tag = "R1";
        end else begin
            act     = src_req | m_soft;
            e_pend  = act & m_en & ~m_sel;
            e_irq   = (e_pend != 0);
            e_fiq   = ((act & m_sel) != 0);
            e_rdata = bus_rd ? m_read(bus_word, act) : 32'h0;
            e_tag   = bus_rd ? tag_of(bus_word) : "R11";
            if (bus_wr) begin
                case (bus_word)
                    10'd3: m_sel  = bus_wdata;
                    10'd4: m_en   = m_en | bus_wdata;
                    10'd5: m_en   = m_en & ~bus_wdata;
                    10'd6: m_soft = m_soft | bus_wdata;
                    10'd7: m_soft = m_soft & ~bus_wdata;
                    10'd8: m_prot = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(bus_rdata === e_rdata, e_tag, bus_rdata, e_rdata);
            check(irq_pend === e_pend, "R3 pend", irq_pend, e_pend);
            check(irq_out === e_irq, "R3 irq", {31'h0, irq_out}, {31'h0, e_irq});
            check(fiq_out === e_fiq, "R4 fiq", {31'h0, fiq_out}, {31'h0, e_fiq});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic do_wr(input logic [9:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [9:0] w, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_word = w;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs cleared by reset
        check(irq_out === 1'b0, "R1 irq", {31'h0, irq_out}, 32'h0);
        check(fiq_out === 1'b0, "R1 fiq", {31'h0, fiq_out}, 32'h0);
        check(bus_rdata === 32'h0, "R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        rd_chk(10'd4, 32'h0, "R1 enable");
        rd_chk(10'd6, 32'h0, "R1 soft");
        rd_chk(10'd3, 32'h0, "R1 route");
        rd_chk(10'd8, 32'h0, "R1 prot");

        // R2/R5: hardware requests with no enable, then enable set and clear
        src_req = 32'h0000_00F0;
        rd_chk(10'd2, 32'h0000_00F0, "R2 raw");
        rd_chk(10'd0, 32'h0, "R2 irq status");
        do_wr(10'd4, 32'h0000_0030);
        rd_chk(10'd4, 32'h0000_0030, "R5 set");
        rd_chk(10'd0, 32'h0000_0030, "R2 irq status enabled");
        check(irq_out === 1'b1, "R3 irq", {31'h0, irq_out}, 32'h1);
        do_wr(10'd5, 32'h0000_0010);
        rd_chk(10'd4, 32'h0000_0020, "R5 clear");

        // R4/R7: fast routing bypasses enable
        do_wr(10'd3, 32'h8000_0080);
        rd_chk(10'd3, 32'h8000_0080, "R7 route");
        rd_chk(10'd1, 32'h0000_0080, "R2 fiq status");
        check(fiq_out === 1'b1, "R4 fiq without enable", {31'h0, fiq_out}, 32'h1);

        // R6: software requests
        do_wr(10'd6, 32'h0001_0000);
        rd_chk(10'd6, 32'h0001_0000, "R6 set");
        rd_chk(10'd2, 32'h0001_00F0, "R2 raw with soft");
        do_wr(10'd7, 32'h0001_0000);
        rd_chk(10'd6, 32'h0, "R6 clear");

        // R8: protection flag
        do_wr(10'd8, 32'hFFFF_FFFF);
        rd_chk(10'd8, 32'h1, "R8 set");
        do_wr(10'd8, 32'hFFFF_FFFE);
        rd_chk(10'd8, 32'h0, "R8 clear");

        // R9: identification words
        for (int i = 0; i < 8; i++)
            rd_chk(10'h3F8 + 10'(i), {24'h0, id_tab[i]}, "R9 id");

        // R10: ignored writes and undefined reads
        do_wr(10'd0, 32'hFFFF_FFFF);
        do_wr(10'h100, 32'hFFFF_FFFF);
        do_wr(10'h3F8, 32'hFFFF_FFFF);
        rd_chk(10'd4, 32'h0000_0020, "R10 enable untouched");
        rd_chk(10'd3, 32'h8000_0080, "R10 route untouched");
        rd_chk(10'h100, 32'h0, "R10 undefined");
        rd_chk(10'd5, 32'h0, "R10 clear word");

        // R11: read and write of the same word in one cycle
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_word = 10'd4; bus_wdata = 32'h0000_0F00;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check(bus_rdata === 32'h0000_0020, "R11 same-cycle old value", bus_rdata, 32'h0000_0020);
        rd_chk(10'd4, 32'h0000_0F20, "R11 new value");

        // Random phase, judged by the model every cycle (R2..R11)
        for (int k = 0; k < 600; k++) begin
            int r;
            @(negedge clk);
            r = $urandom % 12;
            src_req   = $urandom & $urandom;
            bus_wr    = ($urandom % 3) == 0;
            bus_rd    = ($urandom % 2) == 0;
            bus_wdata = $urandom;
            if (r < 9)       bus_word = 10'(r);
            else if (r == 9) bus_word = 10'h3F8 + 10'($urandom % 8);
            else             bus_word = 10'($urandom % 1024);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule